// File: doc/BRIEF.md
# Link Status Width/Speed Clamp

This block keeps the negotiated-width and current-speed fields that a port reports in its link status consistent with the link capability that the same port advertises. Its inputs are the port's own capability word and the link status word of the one device attached below the port. A valid flag tells the block whether that device is present and has an express capability.

When a sync strobe is seen, the block works out new width and speed fields and holds them in a register until the next strobe. The downstream device's values are clamped to the port's maximums. A zero field from the device is replaced by the x1 or 2.5 GT/s code. With no usable downstream device, both fields are copied straight from the port's capability. The port's other status bits are not touched: they pass through from the port's own status input.

Width is bits [9:4] and speed is bits [3:0], in both the capability and the status words. Because the positions match, the fields can be compared as plain numbers. The x1 width code is 1, and the 2.5 GT/s speed code is 1.

Top module: `lnk_sta_clamp`

## Requirements
- R1: After reset, and before any sync strobe, the width field (status bits [9:4]) reads 1 and the speed field (status bits [3:0]) reads 1.
- R2: When sync_i is low on a clock edge, the registered width and speed fields do not change, whatever the other inputs do.
- R3: On a strobe with dn_valid_i low, the width field becomes port_cap_i[9:4] and the speed field becomes port_cap_i[3:0].
- R4: On a strobe with dn_valid_i high, a downstream width dn_sta_i[9:4] that is numerically greater than port_cap_i[9:4] is reported as port_cap_i[9:4].
- R5: On a strobe with dn_valid_i high, a downstream width of zero is reported as 1 (x1).
- R6: On a strobe with dn_valid_i high, a downstream speed dn_sta_i[3:0] that is numerically greater than port_cap_i[3:0] is reported as port_cap_i[3:0].
- R7: On a strobe with dn_valid_i high, a downstream speed of zero is reported as 1 (2.5 GT/s).
- R8: On a strobe with dn_valid_i high, a nonzero downstream field that does not exceed the matching capability field is reported unchanged.
- R9: sta_o[15:10] always equals port_sta_i[15:10]. The sync strobe and the clamp logic do not affect these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Recompute strobe |
| port_cap_i | input | 32 | Port link capability word (max width [9:4], max speed [3:0]) |
| port_sta_i | input | 16 | Port's own link status word; its upper bits pass through |
| dn_valid_i | input | 1 | Downstream device present with express capability |
| dn_sta_i | input | 16 | Downstream device link status word |
| sta_o | output | 16 | Port link status with the clamped width and speed fields |
| width_o | output | 6 | Registered width field |
| speed_o | output | 4 | Registered speed field |

## Verification
A strobe that sits on one rising edge shows its result on width_o and speed_o right after that edge, one register stage later. The bench therefore drives a strobe at a falling edge and checks the result at the next falling edge. The hold rule is checked the same way: inputs are changed with the strobe low, and the bench samples at the next falling edge, once the edge that could have altered the register has passed. sta_o[15:10] is combinational, so it is checked in the same half cycle in which port_sta_i changes.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    parameter int WID_BITS  = 6;
    parameter int SPD_BITS  = 4;
    parameter int WID_LSB   = 4;
    parameter int SPD_LSB   = 0;
    parameter int WID_X1    = 1;
    parameter int SPD_GEN1  = 1;

    typedef struct packed {
        logic [WID_BITS-1:0] wid;
        logic [SPD_BITS-1:0] spd;
    } lnk_fields_t;
endpackage

// File: rtl/lsc_field_clamp.sv
module lsc_field_clamp #(
    parameter int FW   = 4,
    parameter int DFLT = 1
) (
    input  logic          dn_ok_i,
    input  logic [FW-1:0] cap_i,
    input  logic [FW-1:0] dn_i,
    output logic [FW-1:0] fld_o
);
    localparam logic [FW-1:0] DFLT_V = FW'(DFLT);

    always_comb begin
        if (!dn_ok_i)
            fld_o = cap_i;
        else if (dn_i > cap_i)
            fld_o = cap_i;
        else if (dn_i == '0)
            fld_o = DFLT_V;
        else
            fld_o = dn_i;
    end
endmodule

// File: rtl/lnk_sta_clamp.sv
module lnk_sta_clamp
    import lsc_pkg::*;
#(
    parameter int CAP_W = 32,
    parameter int STA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_i,
    input  logic [CAP_W-1:0]    port_cap_i,
    input  logic [STA_W-1:0]    port_sta_i,
    input  logic                dn_valid_i,
    input  logic [STA_W-1:0]    dn_sta_i,
    output logic [STA_W-1:0]    sta_o,
    output logic [WID_BITS-1:0] width_o,
    output logic [SPD_BITS-1:0] speed_o
);
    localparam int FLD_TOP = WID_LSB + WID_BITS;

    lnk_fields_t cap_f, dn_f, clamp_f;
    lnk_fields_t fld_d, fld_q;

    assign cap_f.wid = port_cap_i[WID_LSB +: WID_BITS];
    assign cap_f.spd = port_cap_i[SPD_LSB +: SPD_BITS];
    assign dn_f.wid  = dn_sta_i[WID_LSB +: WID_BITS];
    assign dn_f.spd  = dn_sta_i[SPD_LSB +: SPD_BITS];

    lsc_field_clamp #(.FW(WID_BITS), .DFLT(WID_X1)) u_wid (
        .dn_ok_i (dn_valid_i),
        .cap_i   (cap_f.wid),
        .dn_i    (dn_f.wid),
        .fld_o   (clamp_f.wid)
    );

    lsc_field_clamp #(.FW(SPD_BITS), .DFLT(SPD_GEN1)) u_spd (
        .dn_ok_i (dn_valid_i),
        .cap_i   (cap_f.spd),
        .dn_i    (dn_f.spd),
        .fld_o   (clamp_f.spd)
    );

    always_comb begin
        fld_d = fld_q;
        if (sync_i)
            fld_d = clamp_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q.wid <= WID_BITS'(WID_X1);
            fld_q.spd <= SPD_BITS'(SPD_GEN1);
        end else begin
            fld_q <= fld_d;
        end
    end

    assign width_o = fld_q.wid;
    assign speed_o = fld_q.spd;

    always_comb begin
        sta_o = port_sta_i;
        sta_o[WID_LSB +: WID_BITS] = fld_q.wid;
        sta_o[SPD_LSB +: SPD_BITS] = fld_q.spd;
    end

    // R2
    hold_no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> ($stable(width_o) && $stable(speed_o)));

    // R3
    no_dev_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !dn_valid_i) |=>
        (width_o == $past(port_cap_i[WID_LSB +: WID_BITS]) &&
         speed_o == $past(port_cap_i[SPD_LSB +: SPD_BITS])));

    // R4
    wid_cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && dn_valid_i && port_cap_i[WID_LSB +: WID_BITS] != '0) |=>
        (width_o <= $past(port_cap_i[WID_LSB +: WID_BITS])));

    // R6
    spd_cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && dn_valid_i && port_cap_i[SPD_LSB +: SPD_BITS] != '0) |=>
        (speed_o <= $past(port_cap_i[SPD_LSB +: SPD_BITS])));

    // R5
    wid_zero_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && dn_valid_i && dn_sta_i[WID_LSB +: WID_BITS] == '0) |=>
        (width_o == WID_BITS'(WID_X1)));

    // R7
    spd_zero_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && dn_valid_i && dn_sta_i[SPD_LSB +: SPD_BITS] == '0) |=>
        (speed_o == SPD_BITS'(SPD_GEN1)));

    // R9
    upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sta_o[STA_W-1:FLD_TOP] == port_sta_i[STA_W-1:FLD_TOP]);
endmodule

// File: tb/lnk_sta_clamp_test.sv
module lnk_sta_clamp_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic [31:0] port_cap_i = '0;
    logic [15:0] port_sta_i = '0;
    logic        dn_valid_i = 1'b0;
    logic [15:0] dn_sta_i = '0;
    logic [15:0] sta_o;
    logic [5:0]  width_o;
    logic [3:0]  speed_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_sta_clamp uut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
        .port_cap_i(port_cap_i), .port_sta_i(port_sta_i),
        .dn_valid_i(dn_valid_i), .dn_sta_i(dn_sta_i),
        .sta_o(sta_o), .width_o(width_o), .speed_o(speed_o)
    );

    function automatic logic [5:0] exp_w(logic v, logic [5:0] c, logic [5:0] d);
        if (!v) return c;
        if (d > c) return c;
        if (d == 0) return 6'd1;
        return d;
    endfunction

    function automatic logic [3:0] exp_s(logic v, logic [3:0] c, logic [3:0] d);
        if (!v) return c;
        if (d > c) return c;
        if (d == 0) return 4'd1;
        return d;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // strobe with given inputs, check result after the capturing edge
    task automatic strobe(string req, logic v, logic [31:0] cap, logic [15:0] dn);
        logic [5:0] ew;
        logic [3:0] es;
        port_cap_i = cap;
        dn_valid_i = v;
        dn_sta_i   = dn;
        sync_i     = 1'b1;
        ew = exp_w(v, cap[9:4], dn[9:4]);
        es = exp_s(v, cap[3:0], dn[3:0]);
        @(negedge clk);
        sync_i = 1'b0;
        check({req, " width"}, 32'(width_o), 32'(ew));
        check({req, " speed"}, 32'(speed_o), 32'(es));
        check({req, " sta fields"}, 32'(sta_o[9:0]), 32'({ew, es}));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 width", 32'(width_o), 32'd1);
        check("R1 speed", 32'(speed_o), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 width after release", 32'(width_o), 32'd1);
        check("R1 speed after release", 32'(speed_o), 32'd1);

        // R3 no downstream device
        strobe("R3", 1'b0, 32'h0000_0083, 16'h0011);
        // R4 width above cap, R6 speed above cap
        strobe("R4 R6", 1'b1, 32'h0000_0042, 16'h0105);
        // R5 width zero, R7 speed zero
        strobe("R5 R7", 1'b1, 32'h0000_0084, 16'h0000);
        // R8 in range passes
        strobe("R8", 1'b1, 32'h0000_0104, 16'h0083);
        // R8 equal to cap boundary
        strobe("R8 equal", 1'b1, 32'h0000_0104, 16'h0104);

        // R2 hold: change inputs without strobe
        port_cap_i = 32'h0000_03F0;
        dn_valid_i = 1'b0;
        dn_sta_i   = 16'hFFFF;
        @(negedge clk);
        check("R2 width hold", 32'(width_o), 32'h10);
        check("R2 speed hold", 32'(speed_o), 32'h4);

        // R9 upper bits pass through
        port_sta_i = 16'hA5A5;
        #1;
        check("R9 upper", 32'(sta_o[15:10]), 32'(6'h29));
        port_sta_i = 16'h5C00;
        #1;
        check("R9 upper", 32'(sta_o[15:10]), 32'(6'h17));

        // random mix
        for (int i = 0; i < 200; i++) begin
            logic [31:0] c;
            logic [15:0] d;
            logic        v;
            c = $urandom;
            d = 16'($urandom);
            v = 1'($urandom);
            port_sta_i = 16'($urandom);
            strobe(v ? "R4 R5 R6 R7 R8 random" : "R3 random", v, c, d);
            check("R9 random", 32'(sta_o[15:10]), 32'(port_sta_i[15:10]));
            if (($urandom % 4) == 0) begin
                logic [5:0] hw;
                logic [3:0] hs;
                hw = width_o;
                hs = speed_o;
                dn_sta_i = 16'($urandom);
                port_cap_i = $urandom;
                dn_valid_i = 1'($urandom);
                @(negedge clk);
                check("R2 random hold", 32'({width_o, speed_o}), 32'({hw, hs}));
            end
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule